// File: doc/BRIEF.md
# Segmented Scaled-Index Linear Address Generator

This block turns one address request into a 32-bit linear address. The request holds a mode code, selectors for a base and an index register in a small general-purpose register file, a selector for one of six segment base registers, a 2-bit scale code, a displacement of selectable width and the program counter. The mode decides which addends go into one sum. That sum can take the selected segment base or the program counter, a base register, an index register shifted left by the scale code, and a sign-extended displacement.

Both register files sit inside the block and each has its own write port. A request reads the register values held before any write made in the same cycle. The sum is registered, so the address and its valid flag appear one clock after the request. A request with an illegal mode code, or a segmented request that names a segment register that does not exist, gives no valid output. The output register keeps the last legal address until the next legal request.

Top module: `agu_linear_addr`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, out_addr is 0, and every general register and segment base register reads as 0.
- R2: A write to a general register (gpr_we) or a segment base register (seg_we) changes the stored value at the clock edge. A request in the same cycle uses the old value, and requests from the next cycle on use the new one.
- R3: req_disp_size selects the displacement. 0 gives no displacement (zero). 1 takes req_disp[7:0] and 2 takes req_disp[15:0], each sign-extended to 32 bits. 3 takes all 32 bits.
- R4: req_scale code s multiplies the index value by 2^s (1, 2, 4 or 8), using a left shift that drops bits shifted out.
- R5: Segmented modes add the segment base selected by req_seg. Mode 0 gives seg+disp. Mode 1 gives seg+base. Mode 2 gives seg+base+disp. Mode 3 gives seg+(index scaled)+disp. Mode 5 gives seg+base+(index scaled)+disp.
- R6: Mode 4 gives seg+base+index+disp and ignores req_scale.
- R7: Mode 6 (relative) gives req_pc+disp. It adds no segment base and ignores req_seg, including values 6 and 7.
- R8: Every sum wraps modulo 2^32.
- R9: A legal request (req_valid=1) makes out_valid 1 and shows its address on out_addr in the next cycle.
- R10: Mode 7 is illegal. A segmented mode with req_seg of 6 or more is also illegal. Either one, and also req_valid=0, gives out_valid=0 in the next cycle.
- R11: out_addr holds its last value in every cycle that follows a request that is not legal or not valid.
- R12: Mode 0 ignores the base and index registers, and mode 1 ignores the displacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gpr_we | input | 1 | General register write enable |
| gpr_waddr | input | 3 | General register write address |
| gpr_wdata | input | 32 | General register write data |
| seg_we | input | 1 | Segment base write enable |
| seg_waddr | input | 3 | Segment base write address (0..5) |
| seg_wdata | input | 32 | Segment base write data |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_seg | input | 3 | Segment base selector |
| req_base | input | 3 | Base register selector |
| req_index | input | 3 | Index register selector |
| req_scale | input | 2 | Index scale code |
| req_disp_size | input | 2 | Displacement width code |
| req_disp | input | 32 | Displacement field |
| req_pc | input | 32 | Program counter for relative mode |
| out_valid | output | 1 | Linear address valid |
| out_addr | output | 32 | Linear address |

## Verification
A wrong register-file entry shows up in the first later request that selects it, one clock after that request, as a wrong out_addr. That entry then stays wrong until it is written again. A wrong legality decision shows up one cycle later on out_valid. A wrongly held output register shows up as a changed out_addr after an idle or illegal cycle. The bench therefore checks out_valid and out_addr in every cycle and mixes register writes between requests, so an error is caught in the cycle it first reaches the ports.

// File: rtl/agu_pkg.sv
// Package: shared types for the linear address generator.
// Assumes a 3-bit mode code and a 2-bit displacement width code.
package agu_pkg;

    typedef enum logic [2:0] {
        MD_DISP           = 3'd0,
        MD_BASE           = 3'd1,
        MD_BASE_DISP      = 3'd2,
        MD_SIDX_DISP      = 3'd3,
        MD_BASE_IDX_DISP  = 3'd4,
        MD_BASE_SIDX_DISP = 3'd5,
        MD_REL            = 3'd6,
        MD_BAD            = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        DW_NONE = 2'd0,
        DW_BYTE = 2'd1,
        DW_HALF = 2'd2,
        DW_WORD = 2'd3
    } disp_width_e;

    // Which addends a mode feeds into the sum
    typedef struct packed {
        logic legal;
        logic use_pc;
        logic use_base;
        logic use_index;
        logic use_scale;
        logic use_disp;
    } addend_sel_t;

    // Map a mode code onto its addend selection
    function automatic addend_sel_t decode_mode(input logic [2:0] mode);
        addend_sel_t s;
        s = '0;
        unique case (mode)
            MD_DISP:           begin s.legal = 1'b1; s.use_disp = 1'b1; end
            MD_BASE:           begin s.legal = 1'b1; s.use_base = 1'b1; end
            MD_BASE_DISP:      begin s.legal = 1'b1; s.use_base = 1'b1; s.use_disp = 1'b1; end
            MD_SIDX_DISP:      begin s.legal = 1'b1; s.use_index = 1'b1; s.use_scale = 1'b1;
                                     s.use_disp = 1'b1; end
            MD_BASE_IDX_DISP:  begin s.legal = 1'b1; s.use_base = 1'b1; s.use_index = 1'b1;
                                     s.use_disp = 1'b1; end
            MD_BASE_SIDX_DISP: begin s.legal = 1'b1; s.use_base = 1'b1; s.use_index = 1'b1;
                                     s.use_scale = 1'b1; s.use_disp = 1'b1; end
            MD_REL:            begin s.legal = 1'b1; s.use_pc = 1'b1; s.use_disp = 1'b1; end
            default:           s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/agu_regfile.sv
// Module: agu_regfile
// A small register file with one synchronous write port and NUM_RD
// combinational read ports. A read returns the value held before a
// write in the same cycle. A read past DEPTH-1 returns zero.
// Assumes a synchronous active-low reset that clears every entry.
module agu_regfile #(
    parameter int DW     = 32,
    parameter int DEPTH  = 8,
    parameter int AW     = 3,
    parameter int NUM_RD = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [DW-1:0]              wdata,
    input  logic [NUM_RD-1:0][AW-1:0]  raddr,
    output logic [NUM_RD-1:0][DW-1:0]  rdata
);

    logic [DW-1:0] entry_q [DEPTH];

    // Storage: one register per entry, written when its address matches
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[e] <= '0;
            else if (we && waddr == AW'(e))
                entry_q[e] <= wdata;
        end
    end

    // Read ports: select the addressed entry, zero when out of range
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rdata[p] = '0;
            for (int e = 0; e < DEPTH; e++) begin
                if (raddr[p] == AW'(e))
                    rdata[p] = entry_q[e];
            end
        end
    end

endmodule

// File: rtl/agu_operand.sv
// Module: agu_operand
// Builds the four addends of the linear address sum from the mode:
// the segment base or the PC, the base value, the scaled index and the
// extended displacement. Unused addends are forced to zero.
// Assumes the register values are already read and that seg_ok says
// whether the segment selector names an existing segment register.
module agu_operand
    import agu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    mode,
    input  logic          seg_ok,
    input  logic [AW-1:0] seg_val,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [1:0]    scale,
    input  logic [1:0]    disp_size,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] pc,
    output logic          legal,
    output logic [AW-1:0] term_origin,
    output logic [AW-1:0] term_base,
    output logic [AW-1:0] term_index,
    output logic [AW-1:0] term_disp
);

    addend_sel_t   sel;
    logic [AW-1:0] disp_ext;

    // Mode decode into addend enables
    always_comb sel = decode_mode(mode);

    // Displacement width selection with sign extension
    always_comb begin
        unique case (disp_width_e'(disp_size))
            DW_NONE: disp_ext = '0;
            DW_BYTE: disp_ext = {{(AW-8){disp[7]}}, disp[7:0]};
            DW_HALF: disp_ext = {{(AW-16){disp[15]}}, disp[15:0]};
            default: disp_ext = disp;
        endcase
    end

    // Legality: known mode, and an existing segment when one is needed
    always_comb legal = sel.legal && (sel.use_pc || seg_ok);

    // Addend gating per mode
    always_comb begin
        term_origin = sel.use_pc    ? pc       : seg_val;
        term_base   = sel.use_base  ? base_val : '0;
        term_disp   = sel.use_disp  ? disp_ext : '0;
        if (!sel.use_index)
            term_index = '0;
        else if (sel.use_scale)
            term_index = index_val << scale;
        else
            term_index = index_val;
    end

endmodule

// File: rtl/agu_sum_stage.sv
// Module: agu_sum_stage
// Adds the four addends modulo 2^AW and registers the result. The
// address register loads only on a legal valid request and otherwise
// holds. The valid flag follows the request with one cycle of latency.
// Assumes a synchronous active-low reset.
module agu_sum_stage #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [AW-1:0] term_origin,
    input  logic [AW-1:0] term_base,
    input  logic [AW-1:0] term_index,
    input  logic [AW-1:0] term_disp,
    output logic          out_valid,
    output logic [AW-1:0] out_addr
);

    logic [AW-1:0] sum;

    // Three-addend-plus-origin sum, wrapping at the word width
    always_comb sum = term_origin + term_base + term_index + term_disp;

    // Output stage: valid follows fire, the address loads only on fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= fire;
            if (fire)
                out_addr <= sum;
        end
    end

    // R11: without a valid output the address register did not move
    a_r11_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_addr));

endmodule

// File: rtl/agu_linear_addr.sv
// Module: agu_linear_addr (top)
// Segmented scaled-index linear address generator. It reads the base
// and index registers and the segment base, builds the addends for the
// requested mode and registers the linear address one cycle later.
// Assumes a synchronous active-low reset and writes that take effect
// at the clock edge, so a request sees the values held before them.
module agu_linear_addr
    import agu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NUM_GPR = 8,
    parameter int NUM_SEG = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        gpr_we,
    input  logic [$clog2(NUM_GPR)-1:0]  gpr_waddr,
    input  logic [AW-1:0]               gpr_wdata,
    input  logic                        seg_we,
    input  logic [$clog2(NUM_SEG)-1:0]  seg_waddr,
    input  logic [AW-1:0]               seg_wdata,
    input  logic                        req_valid,
    input  logic [2:0]                  req_mode,
    input  logic [$clog2(NUM_SEG)-1:0]  req_seg,
    input  logic [$clog2(NUM_GPR)-1:0]  req_base,
    input  logic [$clog2(NUM_GPR)-1:0]  req_index,
    input  logic [1:0]                  req_scale,
    input  logic [1:0]                  req_disp_size,
    input  logic [AW-1:0]               req_disp,
    input  logic [AW-1:0]               req_pc,
    output logic                        out_valid,
    output logic [AW-1:0]               out_addr
);

    localparam int GW = $clog2(NUM_GPR);
    localparam int SW = $clog2(NUM_SEG);
    localparam logic [SW-1:0] SEG_LAST = SW'(NUM_SEG - 1);

    logic [1:0][GW-1:0] gpr_raddr;
    logic [1:0][AW-1:0] gpr_rdata;
    logic [0:0][SW-1:0] seg_raddr;
    logic [0:0][AW-1:0] seg_rdata;
    logic               seg_ok;
    logic               legal;
    logic               fire;
    logic [AW-1:0]      t_origin, t_base, t_index, t_disp;

    // Read address routing for both register files
    always_comb begin
        gpr_raddr[0] = req_base;
        gpr_raddr[1] = req_index;
        seg_raddr[0] = req_seg;
        seg_ok       = (req_seg <= SEG_LAST);
    end

    agu_regfile #(.DW(AW), .DEPTH(NUM_GPR), .AW(GW), .NUM_RD(2)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .waddr (gpr_waddr),
        .wdata (gpr_wdata),
        .raddr (gpr_raddr),
        .rdata (gpr_rdata)
    );

    agu_regfile #(.DW(AW), .DEPTH(NUM_SEG), .AW(SW), .NUM_RD(1)) u_seg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .waddr (seg_waddr),
        .wdata (seg_wdata),
        .raddr (seg_raddr),
        .rdata (seg_rdata)
    );

    agu_operand #(.AW(AW)) u_operand (
        .mode        (req_mode),
        .seg_ok      (seg_ok),
        .seg_val     (seg_rdata[0]),
        .base_val    (gpr_rdata[0]),
        .index_val   (gpr_rdata[1]),
        .scale       (req_scale),
        .disp_size   (req_disp_size),
        .disp        (req_disp),
        .pc          (req_pc),
        .legal       (legal),
        .term_origin (t_origin),
        .term_base   (t_base),
        .term_index  (t_index),
        .term_disp   (t_disp)
    );

    // Request acceptance: valid strobe qualified by legality
    always_comb fire = req_valid && legal;

    agu_sum_stage #(.AW(AW)) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .term_origin (t_origin),
        .term_base   (t_base),
        .term_index  (t_index),
        .term_disp   (t_disp),
        .out_valid   (out_valid),
        .out_addr    (out_addr)
    );

    // R9: a known mode with an existing segment yields a valid output next cycle
    a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != MD_BAD && (req_mode == MD_REL || req_seg <= SEG_LAST))
        |=> out_valid);

    // R10: the illegal mode code never produces a valid output
    a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MD_BAD) |=> !out_valid);

    // R10: no request means no valid output
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R7: relative mode with a full-width displacement is PC plus displacement
    a_r7_relative: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MD_REL && req_disp_size == DW_WORD)
        |=> out_addr == $past(req_pc) + $past(req_disp));

endmodule

// File: tb/tb_agu_linear_addr.sv
module tb_agu_linear_addr;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gpr_we;
    logic [2:0]  gpr_waddr;
    logic [31:0] gpr_wdata;
    logic        seg_we;
    logic [2:0]  seg_waddr;
    logic [31:0] seg_wdata;
    logic        req_valid;
    logic [2:0]  req_mode;
    logic [2:0]  req_seg;
    logic [2:0]  req_base;
    logic [2:0]  req_index;
    logic [1:0]  req_scale;
    logic [1:0]  req_disp_size;
    logic [31:0] req_disp;
    logic [31:0] req_pc;
    logic        out_valid;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_gpr [8];
    logic [31:0] m_seg [6];
    logic [31:0] m_last;

    always #2.5 clk = ~clk;   // 200 MHz

    agu_linear_addr dut (
        .clk(clk), .rst_n(rst_n),
        .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
        .seg_we(seg_we), .seg_waddr(seg_waddr), .seg_wdata(seg_wdata),
        .req_valid(req_valid), .req_mode(req_mode), .req_seg(req_seg),
        .req_base(req_base), .req_index(req_index), .req_scale(req_scale),
        .req_disp_size(req_disp_size), .req_disp(req_disp), .req_pc(req_pc),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] ext_disp(input logic [1:0] ds, input logic [31:0] d);
        case (ds)
            2'd0: return 32'd0;
            2'd1: return {{24{d[7]}}, d[7:0]};
            2'd2: return {{16{d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic bit exp_legal(input logic [2:0] md, input logic [2:0] sg);
        if (md == 3'd7) return 1'b0;
        if (md == 3'd6) return 1'b1;
        return sg < 3'd6;
    endfunction

    function automatic logic [31:0] exp_sum(input logic [2:0] md, input logic [2:0] sg,
                                            input logic [2:0] b, input logic [2:0] ix,
                                            input logic [1:0] sc, input logic [1:0] ds,
                                            input logic [31:0] d, input logic [31:0] pc);
        logic [31:0] sb, bv, iv, dv;
        sb = (sg < 3'd6) ? m_seg[sg] : 32'd0;
        bv = m_gpr[b];
        iv = m_gpr[ix];
        dv = ext_disp(ds, d);
        case (md)
            3'd0: return sb + dv;
            3'd1: return sb + bv;
            3'd2: return sb + bv + dv;
            3'd3: return sb + iv * (32'd1 << sc) + dv;
            3'd4: return sb + bv + iv + dv;
            3'd5: return sb + bv + iv * (32'd1 << sc) + dv;
            default: return pc + dv;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] md);
        case (md)
            3'd4: return "R6";
            3'd6: return "R7";
            3'd7: return "R10";
            default: return "R5";
        endcase
    endfunction

    // One cycle: drive at negedge, update the model at the edge, check the next negedge
    task automatic step(input bit gw, input logic [2:0] ga, input logic [31:0] gd,
                        input bit sw, input logic [2:0] sa, input logic [31:0] sd,
                        input bit v, input logic [2:0] md, input logic [2:0] sg,
                        input logic [2:0] b, input logic [2:0] ix, input logic [1:0] sc,
                        input logic [1:0] ds, input logic [31:0] d, input logic [31:0] pc,
                        input string tag);
        bit ev;
        logic [31:0] ea;
        string t;
        gpr_we = gw; gpr_waddr = ga; gpr_wdata = gd;
        seg_we = sw; seg_waddr = sa; seg_wdata = sd;
        req_valid = v; req_mode = md; req_seg = sg; req_base = b; req_index = ix;
        req_scale = sc; req_disp_size = ds; req_disp = d; req_pc = pc;
        ev = v && exp_legal(md, sg);
        ea = ev ? exp_sum(md, sg, b, ix, sc, ds, d, pc) : m_last;
        @(posedge clk);
        if (gw) m_gpr[ga] = gd;
        if (sw && sa < 3'd6) m_seg[sa] = sd;
        m_last = ea;
        @(negedge clk);
        t = (tag != "") ? tag : (ev ? mode_tag(md) : "R11");
        check(ev ? "R9 valid" : "R10 valid", {31'd0, out_valid}, {31'd0, ev});
        check(t, out_addr, ea);
    endtask

    task automatic wr_gpr(input logic [2:0] a, input logic [31:0] d);
        step(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    endtask

    task automatic wr_seg(input logic [2:0] a, input logic [31:0] d);
        step(0, 0, 0, 1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    endtask

    task automatic req(input logic [2:0] md, input logic [2:0] sg, input logic [2:0] b,
                       input logic [2:0] ix, input logic [1:0] sc, input logic [1:0] ds,
                       input logic [31:0] d, input logic [31:0] pc, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, md, sg, b, ix, sc, ds, d, pc, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0A91);
        for (int k = 0; k < 8; k++) m_gpr[k] = 32'd0;
        for (int k = 0; k < 6; k++) m_seg[k] = 32'd0;
        m_last = 32'd0;
        rst_n = 1'b0;
        gpr_we = 0; gpr_waddr = 0; gpr_wdata = 0;
        seg_we = 0; seg_waddr = 0; seg_wdata = 0;
        req_valid = 0; req_mode = 0; req_seg = 0; req_base = 0; req_index = 0;
        req_scale = 0; req_disp_size = 0; req_disp = 0; req_pc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 addr", out_addr, 32'd0);
        // R1: registers read as zero after reset
        req(3'd5, 3'd5, 3'd7, 3'd3, 2'd3, 2'd0, 0, 0, "R1");

        // R2: same-cycle write is not seen, next cycle is
        step(1, 3'd1, 32'h0000_1000, 1, 3'd0, 32'h0002_0000,
             1, 3'd1, 3'd0, 3'd1, 3'd0, 2'd0, 2'd0, 0, 0, "R2");
        req(3'd1, 3'd0, 3'd1, 3'd0, 0, 0, 0, 0, "R2");
        wr_gpr(3'd2, 32'h0000_0010);
        wr_seg(3'd5, 32'hFFFF_FFF0);

        // R3: displacement widths
        req(3'd0, 3'd0, 0, 0, 0, 2'd1, 32'h0000_0080, 0, "R3");
        req(3'd0, 3'd0, 0, 0, 0, 2'd1, 32'h1234_567F, 0, "R3");
        req(3'd0, 3'd0, 0, 0, 0, 2'd2, 32'h0000_8000, 0, "R3");
        req(3'd0, 3'd0, 0, 0, 0, 2'd0, 32'hDEAD_BEEF, 0, "R3");
        req(3'd0, 3'd0, 0, 0, 0, 2'd3, 32'hDEAD_BEEF, 0, "R3");

        // R4: every scale code
        for (int s = 0; s < 4; s++)
            req(3'd3, 3'd0, 0, 3'd2, 2'(s), 2'd1, 32'h4, 0, "R4");
        req(3'd5, 3'd0, 3'd1, 3'd2, 2'd3, 2'd2, 32'h10, 0, "R5");
        req(3'd2, 3'd0, 3'd1, 0, 0, 2'd1, 32'hF0, 0, "R5");
        // R6: scale ignored in mode 4
        req(3'd4, 3'd0, 3'd1, 3'd2, 2'd3, 2'd0, 0, 0, "R6");
        // R12: mode 1 ignores disp, mode 0 ignores base/index
        req(3'd1, 3'd0, 3'd1, 3'd2, 2'd3, 2'd3, 32'h5555_0000, 0, "R12");
        req(3'd0, 3'd0, 3'd1, 3'd2, 2'd3, 2'd0, 0, 0, "R12");
        // R8: wrap
        req(3'd1, 3'd5, 3'd2, 0, 0, 0, 0, 0, "R8");
        req(3'd6, 3'd0, 0, 0, 0, 2'd3, 32'h8000_0000, 32'h9000_0000, "R8");
        // R7: relative ignores segment, even a missing one
        req(3'd6, 3'd7, 0, 0, 0, 2'd1, 32'h0000_00FC, 32'h0000_1000, "R7");
        // R10 and R11: illegal mode, missing segment, idle
        req(3'd7, 3'd0, 3'd1, 0, 0, 0, 0, 0, "R11");
        req(3'd0, 3'd6, 0, 0, 0, 2'd3, 32'h1, 0, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 3'd1, 3'd0, 3'd1, 0, 0, 0, 0, 0, "R11");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            bit gw, sw, v;
            gw = ($urandom % 4) == 0;
            sw = ($urandom % 6) == 0;
            v  = ($urandom % 8) != 0;
            step(gw, 3'($urandom), $urandom, sw, 3'($urandom % 6), $urandom,
                 v, 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
                 2'($urandom), 2'($urandom), $urandom, $urandom, "");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule